// File: doc/BRIEF.md
# Programmable Clock-Enable Divider with Stop and Source Select

The block turns one of several source clock-enable pulse trains, all running on a common clock, into a divided clock-enable output. One 32-bit control word holds a 6-bit divisor code, a stop flag and a source-select field. A divisor code N divides the selected pulse train by N+1, so ratios run from 1 to 64.

The control word is written through two strobes. A full write replaces all fields. A rate write replaces only the divisor code. The divider latches the control word only when its count wraps. A period that is in progress therefore always completes with its old settings. Divisor changes, source changes, stopping and starting all happen on a period boundary, and the output never emits a shortened or stretched period. A stop request has no effect while the divisor code is zero, so a divide-by-one output cannot be halted.

Top module: `clkdiv6_stop`

## Requirements
- R1: After reset the control word reads 0x0000013F: divisor code 63, stop flag set, source 0. No output pulse appears until a period with the stop flag clear completes.
- R2: With divisor code N in bits [5:0] and the stop flag clear, `clk_en_out` pulses once for every N+1 pulses of the selected source.
- R3: Bit 8 of the control word is the stop flag. While it is 1 and the divisor code is nonzero, `clk_en_out` stays low once the current period ends.
- R4: While the divisor code is zero, the stop flag has no effect and `clk_en_out` follows every selected source pulse.
- R5: Bits [13:12] of the control word select the source. Value k routes `src_pulse[k]`.
- R6: A full write whose source field is equal to or greater than `NSRC` (3 by default) leaves the source field unchanged and still updates the divisor and the stop flag.
- R7: A rate write changes only bits [5:0]. The stop flag and the source field keep their values. A full write takes precedence when both strobes are high.
- R8: New divisor, stop and source values take effect only at the wrap of the current period. A write in mid-period does not change that period's length.
- R9: `clk_en_out` is a one-cycle pulse. It is high in the cycle after the clock edge that samples the selected source pulse completing a period.
- R10: Every control-word bit outside the three fields reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse | input | NSRC | Clock-enable pulse train of each source |
| cfg_wr | input | 1 | Full write of the control word |
| rate_wr | input | 1 | Write of the divisor code only |
| wr_data | input | 32 | Write data |
| cfg_rdata | output | 32 | Current control word |
| clk_en_out | output | 1 | Divided clock-enable pulse |

## Verification
A write is visible on `cfg_rdata` one cycle after the edge that takes it. `clk_en_out` rises one cycle after the edge that samples the pulse completing a period. A new setting shapes the output only after the wrap of the period in progress, which can be up to 64 source pulses later. The bench drives inputs on the falling edge and steps a requirement-level model once per cycle. It compares both outputs at the next falling edge, so every result is sampled in exactly the cycle it is due. The directed cases count pulses over windows that are whole multiples of the period, and they first wait out the longest possible old period, so the counts do not depend on phase.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
    parameter int DIV_W     = 6;
    parameter int STOP_BIT  = 8;
    parameter int SEL_SHIFT = 12;
    parameter int SEL_W     = 2;
    parameter int WORD_W    = 32;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             stop;
        logic [DIV_W-1:0] div;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{sel: '0, stop: 1'b1, div: '1};

    function automatic logic [WORD_W-1:0] cfg_to_word(input cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[DIV_W-1:0]            = c.div;
        w[STOP_BIT]             = c.stop;
        w[SEL_SHIFT +: SEL_W]   = c.sel;
        return w;
    endfunction
endpackage

// File: rtl/cdiv_ctl_reg.sv
module cdiv_ctl_reg
    import cdiv_pkg::*;
#(
    parameter int NSRC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              rate_wr,
    input  logic [WORD_W-1:0] wd,
    output cfg_t              cfg
);
    localparam logic [SEL_W:0] NSRC_L = NSRC[SEL_W:0];

    logic [SEL_W-1:0] sel_in;
    logic             sel_ok;
    logic             unused_wd;

    assign sel_in    = wd[SEL_SHIFT +: SEL_W];
    assign sel_ok    = ({1'b0, sel_in} < NSRC_L);
    assign unused_wd = ^wd;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (cfg_wr) begin
            cfg.div  <= wd[DIV_W-1:0];
            cfg.stop <= wd[STOP_BIT];
            if (sel_ok) cfg.sel <= sel_in;
        end else if (rate_wr) begin
            cfg.div <= wd[DIV_W-1:0];
        end
    end

    // R6: stored selection always names a connected source
    a_r6_sel_in_range: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, cfg.sel} < NSRC_L));

    // R7: a rate-only write leaves stop flag and selection alone
    a_r7_rate_only: assert property (@(posedge clk) disable iff (rst)
        (rate_wr && !cfg_wr) |=> ($stable(cfg.stop) && $stable(cfg.sel)));
endmodule

// File: rtl/cdiv_src_pick.sv
module cdiv_src_pick
    import cdiv_pkg::*;
#(
    parameter int NSRC = 3
) (
    input  logic [NSRC-1:0]  src_pulse,
    input  logic [SEL_W-1:0] sel,
    output logic             pulse
);
    logic [NSRC-1:0] hit;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam logic [SEL_W-1:0] IDX = i[SEL_W-1:0];
        assign hit[i] = src_pulse[i] && (sel == IDX);
    end

    assign pulse = |hit;
endmodule

// File: rtl/cdiv_core.sv
module cdiv_core
    import cdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pulse,
    input  cfg_t req,
    output cfg_t act,
    output logic tick
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap = pulse && (cnt == act.div);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            act  <= CFG_RESET;
            tick <= 1'b0;
        end else begin
            tick <= wrap && !act.stop;
            if (wrap) begin
                cnt      <= '0;
                act.div  <= req.div;
                act.stop <= req.stop && (req.div != '0);
                act.sel  <= req.sel;
            end else if (pulse) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2: count never passes the active terminal value
    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= act.div);

    // R8: active settings only change on a wrap
    a_r8_hold_mid_period: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(act));

    // R4: a zero divisor can never be in the stopped state
    a_r4_zero_runs: assert property (@(posedge clk) disable iff (rst)
        act.stop |-> (act.div != '0));

    // R9: an output pulse always follows a period start
    a_r9_tick_after_wrap: assert property (@(posedge clk) disable iff (rst)
        tick |-> (cnt == '0));
endmodule

// File: rtl/clkdiv6_stop.sv
module clkdiv6_stop
    import cdiv_pkg::*;
#(
    parameter int NSRC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_pulse,
    input  logic              cfg_wr,
    input  logic              rate_wr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] cfg_rdata,
    output logic              clk_en_out
);
    cfg_t cfg;
    cfg_t act;
    logic pulse;

    cdiv_ctl_reg #(.NSRC(NSRC)) u_reg (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .rate_wr(rate_wr),
        .wd(wr_data), .cfg(cfg)
    );

    cdiv_src_pick #(.NSRC(NSRC)) u_pick (
        .src_pulse(src_pulse), .sel(act.sel), .pulse(pulse)
    );

    cdiv_core u_core (
        .clk(clk), .rst(rst), .pulse(pulse), .req(cfg),
        .act(act), .tick(clk_en_out)
    );

    assign cfg_rdata = cfg_to_word(cfg);

    // R10: bits outside the fields read zero
    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata & ~32'h0000_313F) == 32'h0);
endmodule

// File: tb/sim_clkdiv6_stop.sv
`timescale 1ns/1ps
module sim_clkdiv6_stop;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  src_pulse = '0;
    logic        cfg_wr = 1'b0;
    logic        rate_wr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] cfg_rdata;
    logic        clk_en_out;

    int checks = 0;
    int fails = 0;
    int tcount = 0;
    int cyc_n = 0;

    // model state
    logic [5:0] m_div = 6'd63;
    logic       m_stop = 1'b1;
    logic [1:0] m_sel = 2'd0;
    logic [5:0] a_div = 6'd63;
    logic       a_stop = 1'b1;
    logic [1:0] a_sel = 2'd0;
    logic [5:0] m_cnt = '0;
    logic       m_tick = 1'b0;

    always #4 clk = ~clk;

    clkdiv6_stop u0 (
        .clk(clk), .rst(rst), .src_pulse(src_pulse), .cfg_wr(cfg_wr),
        .rate_wr(rate_wr), .wr_data(wr_data), .cfg_rdata(cfg_rdata),
        .clk_en_out(clk_en_out)
    );

    function automatic logic [31:0] exp_word();
        return {18'b0, m_sel, 3'b0, m_stop, 2'b0, m_div};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic cw, input logic rw, input logic [31:0] wd);
        logic [2:0] s;
        logic       p;
        logic       wrap;
        s[0] = 1'b1;
        s[1] = cyc_n[0];
        s[2] = (($urandom % 3) == 0);
        src_pulse = s; cfg_wr = cw; rate_wr = rw; wr_data = wd;
        p    = s[a_sel];
        wrap = p && (m_cnt == a_div);
        m_tick = wrap && !a_stop;
        if (wrap) begin
            m_cnt  = '0;
            a_div  = m_div;
            a_stop = m_stop && (m_div != 0);
            a_sel  = m_sel;
        end else if (p) begin
            m_cnt = m_cnt + 1'b1;
        end
        if (cw) begin
            m_div  = wd[5:0];
            m_stop = wd[8];
            if (wd[13:12] < 2'd3) m_sel = wd[13:12];
        end else if (rw) begin
            m_div = wd[5:0];
        end
        cyc_n++;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0; rate_wr = 1'b0;
        chk("R2 R3 R4 R5 R8 R9 output pulse", {31'b0, clk_en_out}, {31'b0, m_tick});
        chk("R6 R7 R10 control word", cfg_rdata, exp_word());
        if (clk_en_out) tcount++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 32'h0);
    endtask

    task automatic count_ticks(input int n, input int exp, input string tag);
        tcount = 0;
        idle(n);
        chk(tag, tcount, exp);
    endtask

    initial begin
        #1_600_000;
        fails++;
        $display("FAIL watchdog expired actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset control word", cfg_rdata, 32'h0000_013F);
        chk("R1 reset output", {31'b0, clk_en_out}, 32'h0);
        count_ticks(80, 0, "R1 stopped after reset");

        // R4: stop flag ignored with divisor code zero
        cyc(1'b1, 1'b0, 32'h0000_0100);
        idle(80);
        count_ticks(10, 10, "R4 zero divisor ignores stop");

        // R5: select source 1 (every other cycle), divide by 1
        cyc(1'b1, 1'b0, 32'h0000_1000);
        idle(10);
        count_ticks(20, 10, "R5 source 1 selected");

        // R7: rate write keeps stop and select
        cyc(1'b0, 1'b1, 32'h0000_3105);
        chk("R7 rate write", cfg_rdata, 32'h0000_1005);

        // R6: invalid select keeps old selection
        cyc(1'b1, 1'b0, 32'h0000_3002);
        chk("R6 invalid select", cfg_rdata, 32'h0000_1002);
        idle(20);
        count_ticks(60, 10, "R2 divide by 3 on source 1");

        // R3: stop with nonzero divisor
        cyc(1'b1, 1'b0, 32'h0000_1102);
        idle(10);
        count_ticks(30, 0, "R3 stopped");

        // R8: mid-period divisor change waits for the wrap
        cyc(1'b1, 1'b0, 32'h0000_003F);
        idle(140);
        for (int i = 0; i < 200 && !clk_en_out; i++) idle(1);
        idle(10);
        cyc(1'b1, 1'b0, 32'h0000_0000);
        count_ticks(40, 0, "R8 old period kept");
        idle(30);
        count_ticks(10, 10, "R8 new divisor after wrap");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 40) == 0) begin
                logic [31:0] w;
                w = 32'h0;
                w[5:0]   = (($urandom % 4) == 0) ? 6'($urandom % 64) : 6'($urandom % 8);
                w[8]     = 1'($urandom % 2);
                w[13:12] = 2'($urandom % 4);
                w[31:20] = 12'($urandom);
                if (($urandom % 2) == 0) cyc(1'b1, 1'b0, w);
                else cyc(1'b0, 1'b1, w);
            end else begin
                idle(1);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule